// File: doc/BRIEF.md
# Assignable Traffic Counter Bank

This block keeps a bank of byte counters that software binds to memory-traffic sources. Each counter is given three things: a 12-bit source identifier, a flag saying whether that identifier is a monitoring ID or a class-of-service ID, and a 32-bit mask of the event types it should count. Traffic events arrive on a separate port, one per cycle. Each event carries a monitoring ID, a class ID, an event-type index and a byte count. Every enabled counter whose assignment matches the event adds the event's bytes in the same cycle, so one event can update several counters at once.

Software programs the block through one 64-bit staging register. The register is written in 32-bit halves, selected by a two-bit half strobe, so a setup can be built up over several writes. A setup takes effect only on a write to the upper half that has the commit bit set. That write installs the staged fields into the counter it names and clears that counter. A separate enable bit decides whether the counter then counts or stays idle.

Accesses made while the feature input is low are refused with a fault pulse. Writes that set reserved bits are refused with an error pulse. A read port returns any counter's value.

Top module: `amon_bank`

## Requirements
- R1: After reset every counter reads 0, the staging register reads 0, and `cfg_fault` and `cfg_err` are low.
- R2: A write with `cfg_be[0]` set loads staging bits 31:0. A write with `cfg_be[1]` set loads staging bits 63:32. A `cfg_rd` returns the staging value on `cfg_rdata` one cycle later, as it stood before any write in the same cycle.
- R3: Staging field layout: bit 63 commit, bit 62 count enable, bits 52:48 counter number, bit 47 class-ID flag, bits 43:32 source ID, bits 31:0 type mask. A write with `cfg_be[1]` and bit 63 set applies the merged staged value to the named counter and clears that counter to 0. No other write changes any counter's assignment.
- R4: A commit with bit 62 = 0 installs the assignment, but the counter stays at 0 when matching events arrive.
- R5: An enabled counter adds `ev_bytes` when `ev_valid` is high, its mask bit at index `ev_type` is 1, and its source ID equals `ev_cls_id` (flag = 1) or `ev_mon_id` (flag = 0).
- R6: An upper-half write with any of bits 61:53 or 46:44 set pulses `cfg_err` for one cycle. It changes neither the staging register nor any counter.
- R7: While `feat_en` is low, any `cfg_wr` or `cfg_rd` pulses `cfg_fault` one cycle later. Such an access changes no state, and a refused read returns 0 on `cfg_rdata`.
- R8: Counters are 48 bits wide and wrap modulo 2^48.
- R9: One event adds its bytes to every counter whose assignment matches it, in the same cycle.
- R10: A counter read in the same cycle as a commit to that counter returns 0.
- R11: `rd_data` presents the value of counter `rd_idx` one cycle after `rd_en`. That value excludes any event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_en | input | 1 | Feature enable; configuration access is refused while low |
| cfg_wr | input | 1 | Staging register write strobe |
| cfg_rd | input | 1 | Staging register read strobe |
| cfg_be | input | 2 | Half select: bit 0 lower word, bit 1 upper word |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Staging register read data |
| cfg_fault | output | 1 | One-cycle pulse: access refused, feature disabled |
| cfg_err | output | 1 | One-cycle pulse: reserved bit set, write ignored |
| ev_valid | input | 1 | Event valid |
| ev_mon_id | input | 12 | Event monitoring ID |
| ev_cls_id | input | 12 | Event class-of-service ID |
| ev_type | input | 5 | Event type index into the mask |
| ev_bytes | input | BYTE_W | Event byte count |
| rd_en | input | 1 | Counter read strobe |
| rd_idx | input | 5 | Counter number to read |
| rd_data | output | 48 | Counter read data |

## Verification
The checker assumes that `cfg_be` is driven only while `cfg_wr` is high. It also assumes that each access is one clean single-cycle strobe, sampled on the rising edge. Neither strobe is stretched, and `feat_en` does not toggle inside an access.

The bench drives every input on the falling edge and drops each strobe after one cycle. It changes `feat_en` only between accesses. Its counter numbers stay below the bank size, and each event's byte count fits within the counter width.

// File: rtl/amon_bank.sv
module amon_bank #(
  parameter int NUM_CTR = 32,
  parameter int CNT_W   = 48,
  parameter int BYTE_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feat_en,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [1:0]        cfg_be,
  input  logic [63:0]       cfg_wdata,
  output logic [63:0]       cfg_rdata,
  output logic              cfg_fault,
  output logic              cfg_err,
  input  logic              ev_valid,
  input  logic [11:0]       ev_mon_id,
  input  logic [11:0]       ev_cls_id,
  input  logic [4:0]        ev_type,
  input  logic [BYTE_W-1:0] ev_bytes,
  input  logic              rd_en,
  input  logic [4:0]        rd_idx,
  output logic [CNT_W-1:0]  rd_data
);
  localparam logic [31:0] RSV_HI = 32'h3FE0_7000;

  logic [63:0] stg;
  logic [CNT_W-1:0] cnt [NUM_CTR];
  logic [11:0] src [NUM_CTR];
  logic [31:0] msk [NUM_CTR];
  logic        cls [NUM_CTR];
  logic        ena [NUM_CTR];

  wire         rsv_bad = cfg_wr & cfg_be[1] & (|(cfg_wdata[63:32] & RSV_HI));
  wire         wr_ok   = cfg_wr & feat_en & ~rsv_bad;
  wire [63:0]  nxt     = {cfg_be[1] ? cfg_wdata[63:32] : stg[63:32],
                          cfg_be[0] ? cfg_wdata[31:0]  : stg[31:0]};
  wire         commit  = wr_ok & cfg_be[1] & cfg_wdata[63];
  wire [4:0]   cid     = nxt[52:48];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg       <= '0;
      cfg_rdata <= '0;
      cfg_fault <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      cfg_fault <= (cfg_wr | cfg_rd) & ~feat_en;
      cfg_err   <= feat_en & rsv_bad;
      if (cfg_rd) cfg_rdata <= feat_en ? stg : '0;
      if (wr_ok) stg <= nxt;
    end
  end

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    wire [11:0] tag = cls[k] ? ev_cls_id : ev_mon_id;
    wire        hit = ev_valid & ena[k] & (tag == src[k]) & msk[k][ev_type];
    wire        sel = commit & (cid == 5'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt[k] <= '0;
        src[k] <= '0;
        msk[k] <= '0;
        cls[k] <= 1'b0;
        ena[k] <= 1'b0;
      end else if (sel) begin
        cnt[k] <= '0;
        src[k] <= nxt[43:32];
        msk[k] <= nxt[31:0];
        cls[k] <= nxt[47];
        ena[k] <= nxt[62];
      end else if (hit) begin
        cnt[k] <= cnt[k] + CNT_W'(ev_bytes);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) rd_data <= (commit && cid == rd_idx) ? '0 : cnt[rd_idx];
  end
endmodule

module amon_bank_chk #(
  parameter int CNT_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             feat_en,
  input logic             cfg_wr,
  input logic             cfg_rd,
  input logic [1:0]       cfg_be,
  input logic [63:0]      cfg_wdata,
  input logic             cfg_fault,
  input logic             cfg_err,
  input logic [63:0]      stg,
  input logic             rd_en,
  input logic [4:0]       rd_idx,
  input logic [CNT_W-1:0] rd_data
);
  wire rsv = |(cfg_wdata[63:32] & 32'h3FE0_7000);

  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr || cfg_rd) && !feat_en |=> cfg_fault); // R7
  AST_FAULT_KEEPS_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && !feat_en |=> $stable(stg)); // R7
  AST_RSV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && feat_en && cfg_be[1] && rsv |=> $stable(stg) && cfg_err); // R6
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_err, cfg_fault})); // R6
  AST_LOW_HALF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && feat_en && cfg_be == 2'b01 |=> stg[31:0] == $past(cfg_wdata[31:0])); // R2
  AST_COMMIT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && cfg_wr && feat_en && cfg_be[1] && !rsv && cfg_wdata[63] &&
    cfg_wdata[52:48] == rd_idx |=> rd_data == '0); // R10
endmodule

bind amon_bank amon_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
  .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_fault(cfg_fault), .cfg_err(cfg_err),
  .stg(stg), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data));

// File: tb/amon_bank_bench.sv
module amon_bank_bench;
  localparam int BW = 48;
  logic clk = 0, rst_n = 0, feat_en = 1;
  logic cfg_wr = 0, cfg_rd = 0;
  logic [1:0] cfg_be = 0;
  logic [63:0] cfg_wdata = 0, cfg_rdata;
  logic cfg_fault, cfg_err;
  logic ev_valid = 0;
  logic [11:0] ev_mon_id = 0, ev_cls_id = 0;
  logic [4:0] ev_type = 0;
  logic [BW-1:0] ev_bytes = 0;
  logic rd_en = 0;
  logic [4:0] rd_idx = 0;
  logic [47:0] rd_data;

  int total = 0, bad = 0;
  bit done = 0;
  logic [63:0] exp_stg = 0;
  logic last_err, last_fault;

  always #2.5 clk = ~clk;

  amon_bank #(.BYTE_W(BW)) u_amon_bank (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] hi(bit cm, bit en, int ctr, bit c, int s);
    return {cm, en, 9'b0, 5'(ctr), c, 3'b0, 12'(s), 32'b0};
  endfunction

  task automatic cwr(logic [1:0] be, logic [63:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0; cfg_be = 0;
    last_err = cfg_err; last_fault = cfg_fault;
  endtask

  task automatic stage(logic [1:0] be, logic [63:0] d);
    cwr(be, d);
    if (be[1]) exp_stg[63:32] = d[63:32];
    if (be[0]) exp_stg[31:0] = d[31:0];
  endtask

  task automatic crd(output logic [63:0] v);
    @(negedge clk);
    cfg_rd = 1;
    @(negedge clk);
    cfg_rd = 0;
    v = cfg_rdata; last_fault = cfg_fault;
  endtask

  task automatic ev(int m, int c, int t, logic [BW-1:0] b);
    @(negedge clk);
    ev_valid = 1; ev_mon_id = 12'(m); ev_cls_id = 12'(c); ev_type = 5'(t); ev_bytes = b;
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic rd(int i, output logic [47:0] v);
    @(negedge clk);
    rd_en = 1; rd_idx = 5'(i);
    @(negedge clk);
    rd_en = 0;
    v = rd_data;
  endtask

  task automatic t_reset;
    logic [47:0] v; logic [63:0] s;
    rd(0, v); chk("R1 ctr0", v, 0);
    rd(31, v); chk("R1 ctr31", v, 0);
    crd(s); chk("R1 stage", s, 0);
    chk("R1 flags", {cfg_err, cfg_fault}, 0);
  endtask

  task automatic t_stage;
    logic [63:0] s; logic [47:0] v;
    stage(2'b01, 64'h0000_00FF);
    stage(2'b10, hi(0, 1, 3, 0, 12'hABC) | 64'hFFFF);
    chk("R2 no err", last_err, 0);
    crd(s); chk("R2 stage", s, exp_stg);
    ev(12'hABC, 0, 2, 10);
    rd(3, v); chk("R3 no commit yet", v, 0);
  endtask

  task automatic t_commit;
    logic [47:0] v;
    stage(2'b10, hi(1, 1, 3, 0, 12'hABC));
    ev(12'hABC, 0, 2, 100);
    rd(3, v); chk("R5 mon match", v, 100);
    ev(12'hABC, 0, 9, 50);
    rd(3, v); chk("R5 mask bit clear", v, 100);
    ev(12'hABD, 0, 2, 50);
    rd(3, v); chk("R5 wrong id", v, 100);
    ev(0, 12'hABC, 2, 50);
    rd(3, v); chk("R5 class id ignored when flag 0", v, 100);
  endtask

  task automatic t_cls;
    logic [47:0] v;
    stage(2'b01, 64'h10);
    stage(2'b10, hi(1, 1, 4, 1, 12'h055));
    ev(12'h111, 12'h055, 4, 7);
    rd(4, v); chk("R5 class match", v, 7);
    ev(12'h055, 0, 4, 7);
    rd(4, v); chk("R5 mon id ignored when flag 1", v, 7);
  endtask

  task automatic t_idle;
    logic [47:0] v;
    stage(2'b10, hi(1, 0, 5, 0, 12'h055));
    ev(12'h055, 0, 4, 20);
    rd(5, v); chk("R4 idle counter", v, 0);
  endtask

  task automatic t_recommit;
    logic [47:0] v;
    stage(2'b10, hi(1, 1, 3, 0, 12'hABC));
    rd(3, v); chk("R3 commit clears", v, 0);
  endtask

  task automatic t_multi;
    logic [47:0] v;
    stage(2'b10, hi(1, 1, 6, 0, 12'hABC));
    ev(12'hABC, 12'h055, 4, 9);
    rd(3, v); chk("R9 ctr3", v, 9);
    rd(4, v); chk("R9 ctr4", v, 16);
    rd(6, v); chk("R9 ctr6", v, 9);
  endtask

  task automatic t_rdtiming;
    logic [47:0] v;
    @(negedge clk);
    ev_valid = 1; ev_mon_id = 12'hABC; ev_cls_id = 0; ev_type = 4; ev_bytes = 5;
    rd_en = 1; rd_idx = 6;
    @(negedge clk);
    ev_valid = 0; rd_en = 0;
    chk("R11 old value", rd_data, 9);
    rd(6, v); chk("R11 new value", v, 14);
  endtask

  task automatic t_rsv;
    logic [63:0] s; logic [47:0] v;
    cwr(2'b10, hi(1, 1, 6, 0, 12'hABC) | (64'h1 << 53));
    chk("R6 err bit53", last_err, 1);
    chk("R6 no fault", last_fault, 0);
    cwr(2'b11, hi(1, 1, 6, 0, 12'h777) | (64'h1 << 44) | 64'h1);
    chk("R6 err bit44", last_err, 1);
    crd(s); chk("R6 stage kept", s, exp_stg);
    rd(6, v); chk("R6 ctr not cleared", v, 14);
    ev(12'hABC, 0, 4, 1);
    rd(6, v); chk("R6 assignment kept", v, 15);
  endtask

  task automatic t_disabled;
    logic [63:0] s; logic [47:0] v;
    feat_en = 0;
    cwr(2'b11, hi(1, 1, 6, 0, 12'h123) | 64'h1);
    chk("R7 write fault", last_fault, 1);
    chk("R7 no err", last_err, 0);
    crd(s);
    chk("R7 read fault", last_fault, 1);
    chk("R7 read zero", s, 0);
    feat_en = 1;
    rd(6, v); chk("R7 ctr kept", v, 15);
    crd(s); chk("R7 stage kept", s, exp_stg);
    chk("R7 fault clears", last_fault, 0);
  endtask

  task automatic t_rdcommit;
    @(negedge clk);
    cfg_wr = 1; cfg_be = 2'b10; cfg_wdata = hi(1, 1, 6, 0, 12'hABC);
    rd_en = 1; rd_idx = 6;
    @(negedge clk);
    cfg_wr = 0; cfg_be = 0; rd_en = 0;
    exp_stg[63:32] = cfg_wdata[63:32];
    chk("R10 read during commit", rd_data, 0);
  endtask

  task automatic t_wrap;
    logic [47:0] v;
    stage(2'b10, hi(1, 1, 7, 0, 12'h001));
    ev(1, 0, 4, 48'hFFFF_FFFF_FFFF);
    rd(7, v); chk("R8 max", v, 48'hFFFF_FFFF_FFFF);
    ev(1, 0, 4, 2);
    rd(7, v); chk("R8 wrap", v, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_stage; t_commit; t_cls; t_idle; t_recommit; t_multi;
    t_rdtiming; t_rsv; t_disabled; t_rdcommit; t_wrap;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule